// File: doc/BRIEF.md
# RV64IM Instruction Decoder with Packed Control Word

This combinational block turns one uncompressed 32-bit RV64IM instruction into a fixed-format control record for a small execution engine. The record carries three 8-bit register indices, a fully sign-extended 64-bit immediate, nine modifier bits and one of sixteen one-hot operation selectors. All of it except the immediate is packed into a single 49-bit word. Several architectural instructions are folded onto shared datapath operations. The upper-immediate loads become additions. The direct jump becomes a register jump whose base is a pseudo-register at index 255 that holds the program counter. The system call has its operand and result registers rewritten to fixed indices.

The caller expands 16-bit compressed instructions before they reach the block, and raises the compressed-form input so the fact travels on in the control word. The program counter input is returned unchanged beside the decoded record. An encoding outside the supported set raises the illegal output, and the whole control word and immediate are then zero.

Top module: `rv_op_decoder`

## Requirements
- R1: The control word places rs1 in bits 7:0, rs2 in 15:8 and rd in 23:16. The single bits are: 24 register write, 25 two-byte access, 26 four-byte access, 27 eight-byte access, 28 compressed form, 29 signed, 30 alternate-mode select, 31 high/remainder select, 32 32-bit word operation. Bits 33 to 48 are the operation selectors in this order: add, subtract, set-less-than, and, or, xor, shift, jump-register, branch-equal, branch-less-than, load, store, multiply, divide/remainder, system call, breakpoint.
- R2: For every recognised instruction exactly one of the sixteen operation selectors is 1.
- R3: For ALU, LUI, AUIPC, JAL and JALR instructions the register-write bit equals (rd != 0). It is 0 for branches, loads, stores, breakpoint and fence, and 1 for the system call.
- R4: The word bit is 1 exactly for the 32-bit (W) variants. The signed bit is 1 for SLT/SLTI, DIV, REM, BLT, BGE and LB/LH/LW, and for every SRA/SRAI form, MUL, MULW, MULH and MULHSU. It is 0 everywhere else, including LD and all unsigned (U) forms.
- R5: The alternate-mode bit is 1 for SRL/SRA in all forms, MUL, MULW, MULH, BNE, BGE and BGEU. The high/remainder bit is 1 for MULH, MULHU, MULHSU and every REM form. BNE uses the branch-equal selector and BGE/BGEU use the branch-less-than selector.
- R6: Loads and stores mark their width: doubleword sets bit 27, word sets bit 26, halfword sets bit 25, and byte sets none of them. No other instruction sets any of the three.
- R7: LUI decodes as add with rs1 = 0. AUIPC decodes as add with rs1 = 255. For both, the immediate is the 20-bit field placed at bits 31:12 and sign-extended to 64 bits.
- R8: JAL decodes as jump-register with rs1 = 255 and the sign-extended jump offset as immediate, whose bit 0 is always 0. JALR decodes as jump-register with its own rs1 and I-format immediate.
- R9: ECALL (0x00000073) decodes as system call with rs1 = 17, rs2 = 11 and rd = 10. EBREAK (0x00100073) decodes as breakpoint with all indices 0. FENCE (funct3 000) decodes as add with all indices and the immediate 0, whatever its other fields hold.
- R10: A register index or immediate that the instruction's format does not carry is output as 0: rs2 for I and U formats, rd for S and B formats, the immediate for R format.
- R11: I, S and B immediates are sign-extended to 64 bits, SLTIU included. Shift-immediate forms give the shift amount zero-extended: 6 bits for 64-bit shifts and 5 bits for the W shifts.
- R12: An unrecognised encoding raises illegal_o and drives the whole control word and the immediate to 0. This covers a low opcode pair other than 11, unknown opcodes, funct3/funct7 combinations outside RV64IM, non-zero upper shift-immediate bits other than the arithmetic-shift pattern, other SYSTEM words and FENCE.I.
- R13: For a recognised instruction bit 28 equals cmp_i, and pc_o always equals pc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Uncompressed instruction word |
| cmp_i | input | 1 | Instruction arrived in 16-bit compressed form |
| pc_i | input | XLEN (64) | Program counter of the instruction |
| pc_o | output | XLEN (64) | Program counter, passed through |
| ctl_o | output | 3*REG_W+25 (49) | Packed control word |
| imm_o | output | XLEN (64) | Sign-extended immediate |
| illegal_o | output | 1 | Encoding not recognised |

## Verification
The checker assumes that the instruction word and the compressed flag carry defined values. It skips its checks while either is unknown, so the undriven start of a run cannot trip it. It also takes the compressed flag as already paired with an expanded 32-bit word, and never relates it to the opcode. The bench drives a fully defined instruction, flag and program counter before every sample. It sweeps every supported instruction over several register-index and immediate patterns, including rd = 0, the largest indices and the extreme negative offsets, and then covers the fixed system words and a set of malformed encodings.

// File: rtl/rvd_pkg.sv
// Package: shared types for the instruction decoder.
// Holds the operation selector encoding (its numeric order is the bit order
// of the selector field in the control word), the modifier record and the
// immediate format codes. Assumes a 32-bit uncompressed instruction.
package rvd_pkg;

    localparam int NUM_OPS  = 16;
    localparam int NUM_MODS = 9;

    // Fixed register indices written by the system-call remap
    localparam int SYS_NUM_REG = 17;
    localparam int SYS_ARG_REG = 11;
    localparam int SYS_RET_REG = 10;

    // Major opcodes (bits 6:0)
    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
    localparam logic [6:0] OPC_OP      = 7'b0110011;
    localparam logic [6:0] OPC_OP32    = 7'b0111011;
    localparam logic [6:0] OPC_LUI     = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC   = 7'b0010111;
    localparam logic [6:0] OPC_JAL     = 7'b1101111;
    localparam logic [6:0] OPC_JALR    = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;
    localparam logic [6:0] OPC_MISC    = 7'b0001111;

    localparam logic [31:0] WORD_ECALL  = 32'h0000_0073;
    localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

    // Operation selectors; order equals bit order in the control word
    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLT, OP_AND, OP_OR, OP_XOR, OP_SHIFT, OP_JALR,
        OP_BEQ, OP_BLT, OP_LOAD, OP_STORE, OP_MUL, OP_DIVREM, OP_ECALL,
        OP_EBREAK
    } op_e;

    // Immediate formats
    typedef enum logic [2:0] {
        IMM_NONE, IMM_I, IMM_S, IMM_B, IMM_U, IMM_J, IMM_SH6, IMM_SH5
    } imm_kind_e;

    // Operation plus modifier bits produced by the classifier
    typedef struct packed {
        op_e  op;
        logic wr;
        logic m2;
        logic m4;
        logic m8;
        logic sgn;
        logic mp;
        logic md;
        logic word;
    } dec_flags_t;

endpackage

// File: rtl/rvd_classify.sv
// Module: rvd_classify
// Maps one 32-bit instruction to its operation selector, modifier bits,
// register indices and immediate format. Pseudo-register remaps (program
// counter base, system call operands) are applied here. Any encoding outside
// the supported set raises bad_o and clears every other output.
// Assumes the instruction is already expanded from compressed form.
module rvd_classify
    import rvd_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic [31:0]      instr_i,
    output dec_flags_t       flags_o,
    output imm_kind_e        kind_o,
    output logic [REG_W-1:0] rs1_o,
    output logic [REG_W-1:0] rs2_o,
    output logic [REG_W-1:0] rd_o,
    output logic             bad_o
);

    localparam logic [REG_W-1:0] PC_IDX  = {REG_W{1'b1}};
    localparam logic [REG_W-1:0] SYS_NUM = REG_W'(SYS_NUM_REG);
    localparam logic [REG_W-1:0] SYS_ARG = REG_W'(SYS_ARG_REG);
    localparam logic [REG_W-1:0] SYS_RET = REG_W'(SYS_RET_REG);

    logic [6:0]       opc;
    logic [2:0]       f3;
    logic [6:0]       f7;
    logic [REG_W-1:0] fld_rs1;
    logic [REG_W-1:0] fld_rs2;
    logic [REG_W-1:0] fld_rd;
    logic             rd_nz;

    // Field slicing shared by all formats
    always_comb begin
        opc     = instr_i[6:0];
        f3      = instr_i[14:12];
        f7      = instr_i[31:25];
        fld_rs1 = REG_W'(instr_i[19:15]);
        fld_rs2 = REG_W'(instr_i[24:20]);
        fld_rd  = REG_W'(instr_i[11:7]);
        rd_nz   = (instr_i[11:7] != 5'd0);
    end

    dec_flags_t       fl;
    imm_kind_e        kind;
    logic [REG_W-1:0] r1;
    logic [REG_W-1:0] r2;
    logic [REG_W-1:0] rd;
    logic             bad;

    // Per-opcode decision of operation, modifiers, registers and immediate
    always_comb begin
        fl   = '0;
        kind = IMM_NONE;
        r1   = '0;
        r2   = '0;
        rd   = '0;
        bad  = 1'b0;
        case (opc)
            OPC_OPIMM: begin
                r1    = fld_rs1;
                rd    = fld_rd;
                fl.wr = rd_nz;
                kind  = IMM_I;
                case (f3)
                    3'b000: fl.op = OP_ADD;
                    3'b010: begin fl.op = OP_SLT; fl.sgn = 1'b1; end
                    3'b011: fl.op = OP_SLT;
                    3'b100: fl.op = OP_XOR;
                    3'b110: fl.op = OP_OR;
                    3'b111: fl.op = OP_AND;
                    3'b001: begin
                        fl.op = OP_SHIFT;
                        kind  = IMM_SH6;
                        bad   = (instr_i[31:26] != 6'b000000);
                    end
                    default: begin
                        fl.op = OP_SHIFT;
                        kind  = IMM_SH6;
                        fl.mp = 1'b1;
                        if (instr_i[31:26] == 6'b010000) fl.sgn = 1'b1;
                        else if (instr_i[31:26] != 6'b000000) bad = 1'b1;
                    end
                endcase
            end
            OPC_OPIMM32: begin
                r1      = fld_rs1;
                rd      = fld_rd;
                fl.wr   = rd_nz;
                fl.word = 1'b1;
                kind    = IMM_I;
                case (f3)
                    3'b000: fl.op = OP_ADD;
                    3'b001: begin
                        fl.op = OP_SHIFT;
                        kind  = IMM_SH5;
                        bad   = (f7 != 7'b0000000);
                    end
                    3'b101: begin
                        fl.op = OP_SHIFT;
                        kind  = IMM_SH5;
                        fl.mp = 1'b1;
                        if (f7 == 7'b0100000) fl.sgn = 1'b1;
                        else if (f7 != 7'b0000000) bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
            end
            OPC_OP: begin
                r1    = fld_rs1;
                r2    = fld_rs2;
                rd    = fld_rd;
                fl.wr = rd_nz;
                case (f7)
                    7'b0000000: begin
                        case (f3)
                            3'b000: fl.op = OP_ADD;
                            3'b001: fl.op = OP_SHIFT;
                            3'b010: begin fl.op = OP_SLT; fl.sgn = 1'b1; end
                            3'b011: fl.op = OP_SLT;
                            3'b100: fl.op = OP_XOR;
                            3'b101: begin fl.op = OP_SHIFT; fl.mp = 1'b1; end
                            3'b110: fl.op = OP_OR;
                            default: fl.op = OP_AND;
                        endcase
                    end
                    7'b0100000: begin
                        if (f3 == 3'b000) fl.op = OP_SUB;
                        else if (f3 == 3'b101) begin
                            fl.op  = OP_SHIFT;
                            fl.mp  = 1'b1;
                            fl.sgn = 1'b1;
                        end else bad = 1'b1;
                    end
                    7'b0000001: begin
                        case (f3)
                            3'b000: begin
                                fl.op = OP_MUL; fl.mp = 1'b1; fl.sgn = 1'b1;
                            end
                            3'b001: begin
                                fl.op = OP_MUL; fl.mp = 1'b1; fl.sgn = 1'b1;
                                fl.md = 1'b1;
                            end
                            3'b010: begin
                                fl.op = OP_MUL; fl.sgn = 1'b1; fl.md = 1'b1;
                            end
                            3'b011: begin fl.op = OP_MUL; fl.md = 1'b1; end
                            3'b100: begin fl.op = OP_DIVREM; fl.sgn = 1'b1; end
                            3'b101: fl.op = OP_DIVREM;
                            3'b110: begin
                                fl.op = OP_DIVREM; fl.sgn = 1'b1; fl.md = 1'b1;
                            end
                            default: begin fl.op = OP_DIVREM; fl.md = 1'b1; end
                        endcase
                    end
                    default: bad = 1'b1;
                endcase
            end
            OPC_OP32: begin
                r1      = fld_rs1;
                r2      = fld_rs2;
                rd      = fld_rd;
                fl.wr   = rd_nz;
                fl.word = 1'b1;
                case ({f7, f3})
                    {7'b0000000, 3'b000}: fl.op = OP_ADD;
                    {7'b0000000, 3'b001}: fl.op = OP_SHIFT;
                    {7'b0000000, 3'b101}: begin fl.op = OP_SHIFT; fl.mp = 1'b1; end
                    {7'b0100000, 3'b000}: fl.op = OP_SUB;
                    {7'b0100000, 3'b101}: begin
                        fl.op = OP_SHIFT; fl.mp = 1'b1; fl.sgn = 1'b1;
                    end
                    {7'b0000001, 3'b000}: begin
                        fl.op = OP_MUL; fl.mp = 1'b1; fl.sgn = 1'b1;
                    end
                    {7'b0000001, 3'b100}: begin fl.op = OP_DIVREM; fl.sgn = 1'b1; end
                    {7'b0000001, 3'b101}: fl.op = OP_DIVREM;
                    {7'b0000001, 3'b110}: begin
                        fl.op = OP_DIVREM; fl.sgn = 1'b1; fl.md = 1'b1;
                    end
                    {7'b0000001, 3'b111}: begin fl.op = OP_DIVREM; fl.md = 1'b1; end
                    default: bad = 1'b1;
                endcase
            end
            OPC_LUI: begin
                fl.op = OP_ADD;
                rd    = fld_rd;
                fl.wr = rd_nz;
                kind  = IMM_U;
            end
            OPC_AUIPC: begin
                fl.op = OP_ADD;
                r1    = PC_IDX;
                rd    = fld_rd;
                fl.wr = rd_nz;
                kind  = IMM_U;
            end
            OPC_JAL: begin
                fl.op = OP_JALR;
                r1    = PC_IDX;
                rd    = fld_rd;
                fl.wr = rd_nz;
                kind  = IMM_J;
            end
            OPC_JALR: begin
                fl.op = OP_JALR;
                r1    = fld_rs1;
                rd    = fld_rd;
                fl.wr = rd_nz;
                kind  = IMM_I;
                bad   = (f3 != 3'b000);
            end
            OPC_BRANCH: begin
                r1   = fld_rs1;
                r2   = fld_rs2;
                kind = IMM_B;
                case (f3)
                    3'b000: fl.op = OP_BEQ;
                    3'b001: begin fl.op = OP_BEQ; fl.mp = 1'b1; end
                    3'b100: begin fl.op = OP_BLT; fl.sgn = 1'b1; end
                    3'b101: begin fl.op = OP_BLT; fl.sgn = 1'b1; fl.mp = 1'b1; end
                    3'b110: fl.op = OP_BLT;
                    3'b111: begin fl.op = OP_BLT; fl.mp = 1'b1; end
                    default: bad = 1'b1;
                endcase
            end
            OPC_LOAD: begin
                fl.op = OP_LOAD;
                r1    = fld_rs1;
                rd    = fld_rd;
                kind  = IMM_I;
                case (f3)
                    3'b000: fl.sgn = 1'b1;
                    3'b001: begin fl.sgn = 1'b1; fl.m2 = 1'b1; end
                    3'b010: begin fl.sgn = 1'b1; fl.m4 = 1'b1; end
                    3'b011: fl.m8 = 1'b1;
                    3'b100: ;
                    3'b101: fl.m2 = 1'b1;
                    3'b110: fl.m4 = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
            OPC_STORE: begin
                fl.op = OP_STORE;
                r1    = fld_rs1;
                r2    = fld_rs2;
                kind  = IMM_S;
                case (f3)
                    3'b000: ;
                    3'b001: fl.m2 = 1'b1;
                    3'b010: fl.m4 = 1'b1;
                    3'b011: fl.m8 = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
            OPC_SYSTEM: begin
                if (instr_i == WORD_ECALL) begin
                    fl.op = OP_ECALL;
                    fl.wr = 1'b1;
                    r1    = SYS_NUM;
                    r2    = SYS_ARG;
                    rd    = SYS_RET;
                end else if (instr_i == WORD_EBREAK) begin
                    fl.op = OP_EBREAK;
                end else begin
                    bad = 1'b1;
                end
            end
            OPC_MISC: begin
                fl.op = OP_ADD;
                bad   = (f3 != 3'b000);
            end
            default: bad = 1'b1;
        endcase
        if (instr_i[1:0] != 2'b11) bad = 1'b1;
    end

    // Illegal encodings leave nothing behind on the outputs
    always_comb begin
        flags_o = bad ? '0 : fl;
        kind_o  = bad ? IMM_NONE : kind;
        rs1_o   = bad ? '0 : r1;
        rs2_o   = bad ? '0 : r2;
        rd_o    = bad ? '0 : rd;
        bad_o   = bad;
    end

endmodule

// File: rtl/rvd_immgen.sv
// Module: rvd_immgen
// Builds the XLEN-bit immediate for the format chosen by the classifier:
// sign-extended I/S/B/U/J values, zero-extended shift amounts, or zero.
// Assumes XLEN >= 32 and receives instruction bits 31:7 only.
module rvd_immgen
    import rvd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:7]     ibits_i,
    input  imm_kind_e       kind_i,
    output logic [XLEN-1:0] imm_o
);

    localparam int EXT_I = XLEN - 12;
    localparam int EXT_B = XLEN - 13;
    localparam int EXT_U = XLEN - 32;
    localparam int EXT_J = XLEN - 21;

    logic s;

    // Format-dependent assembly and extension of the immediate
    always_comb begin
        s = ibits_i[31];
        case (kind_i)
            IMM_I:   imm_o = {{EXT_I{s}}, ibits_i[31:20]};
            IMM_S:   imm_o = {{EXT_I{s}}, ibits_i[31:25], ibits_i[11:7]};
            IMM_B:   imm_o = {{EXT_B{s}}, s, ibits_i[7], ibits_i[30:25],
                              ibits_i[11:8], 1'b0};
            IMM_U:   imm_o = {{EXT_U{s}}, ibits_i[31:12], 12'h000};
            IMM_J:   imm_o = {{EXT_J{s}}, s, ibits_i[19:12], ibits_i[20],
                              ibits_i[30:21], 1'b0};
            IMM_SH6: imm_o = XLEN'(ibits_i[25:20]);
            IMM_SH5: imm_o = XLEN'(ibits_i[24:20]);
            default: imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rvd_pack.sv
// Module: rvd_pack
// Packs register indices, modifier bits and the one-hot expansion of the
// operation selector into the control word. Field positions follow from
// REG_W; the selector field sits directly above the nine modifier bits.
// Assumes flags and indices are already zero for an illegal encoding.
module rvd_pack
    import rvd_pkg::*;
#(
    parameter int REG_W = 8,
    localparam int MOD_LO  = 3 * REG_W,
    localparam int FLAG_LO = MOD_LO + NUM_MODS,
    localparam int CW_W    = FLAG_LO + NUM_OPS
) (
    input  dec_flags_t       flags_i,
    input  logic [REG_W-1:0] rs1_i,
    input  logic [REG_W-1:0] rs2_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic             cmp_i,
    input  logic             bad_i,
    output logic [CW_W-1:0]  ctl_o
);

    // Register index fields
    assign ctl_o[REG_W-1:0]         = rs1_i;
    assign ctl_o[2*REG_W-1:REG_W]   = rs2_i;
    assign ctl_o[3*REG_W-1:2*REG_W] = rd_i;

    // Modifier bits, compressed flag suppressed on illegal encodings
    assign ctl_o[MOD_LO+0] = flags_i.wr;
    assign ctl_o[MOD_LO+1] = flags_i.m2;
    assign ctl_o[MOD_LO+2] = flags_i.m4;
    assign ctl_o[MOD_LO+3] = flags_i.m8;
    assign ctl_o[MOD_LO+4] = cmp_i & ~bad_i;
    assign ctl_o[MOD_LO+5] = flags_i.sgn;
    assign ctl_o[MOD_LO+6] = flags_i.mp;
    assign ctl_o[MOD_LO+7] = flags_i.md;
    assign ctl_o[MOD_LO+8] = flags_i.word;

    // One-hot operation selectors
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_sel
        assign ctl_o[FLAG_LO+g] = ~bad_i & (flags_i.op == op_e'(g));
    end

endmodule

// File: rtl/rv_op_decoder.sv
// Module: rv_op_decoder (top)
// Combinational decoder from one expanded RV64IM instruction to a packed
// control word and a sign-extended immediate; the program counter is passed
// through beside them. Has no clock or reset: it holds no state.
// Assumes instr_i is a 32-bit form and cmp_i marks its compressed origin.
module rv_op_decoder
    import rvd_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 8,
    localparam int CW_W = 3 * REG_W + NUM_MODS + NUM_OPS
) (
    input  logic [31:0]     instr_i,
    input  logic            cmp_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_o,
    output logic [CW_W-1:0] ctl_o,
    output logic [XLEN-1:0] imm_o,
    output logic            illegal_o
);

    dec_flags_t       flags;
    imm_kind_e        kind;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             bad;

    rvd_classify #(.REG_W(REG_W)) u_classify (
        .instr_i (instr_i),
        .flags_o (flags),
        .kind_o  (kind),
        .rs1_o   (rs1),
        .rs2_o   (rs2),
        .rd_o    (rd),
        .bad_o   (bad)
    );

    rvd_immgen #(.XLEN(XLEN)) u_immgen (
        .ibits_i (instr_i[31:7]),
        .kind_i  (kind),
        .imm_o   (imm_o)
    );

    rvd_pack #(.REG_W(REG_W)) u_pack (
        .flags_i (flags),
        .rs1_i   (rs1),
        .rs2_i   (rs2),
        .rd_i    (rd),
        .cmp_i   (cmp_i),
        .bad_i   (bad),
        .ctl_o   (ctl_o)
    );

    // Program counter travels alongside the decoded record
    assign pc_o      = pc_i;
    assign illegal_o = bad;

endmodule

// File: rtl/rv_op_decoder_chk.sv
// Module: rv_op_decoder_chk
// Immediate-assertion checker on the decoder's ports, bound into every
// instance of rv_op_decoder. Skips while the inputs are unknown.
module rv_op_decoder_chk
    import rvd_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 8,
    localparam int CW_W = 3 * REG_W + NUM_MODS + NUM_OPS
) (
    input logic [31:0]     instr_i,
    input logic            cmp_i,
    input logic [CW_W-1:0] ctl_o,
    input logic [XLEN-1:0] imm_o,
    input logic            illegal_o
);

    localparam int MOD_LO  = 3 * REG_W;
    localparam int FLAG_LO = MOD_LO + NUM_MODS;

    logic [NUM_OPS-1:0] sel;
    logic [2:0]         msz;
    logic [REG_W-1:0]   c_rs1;
    logic [REG_W-1:0]   c_rd;

    // Port-level consistency between the input word and the decoded record
    always_comb begin
        sel   = ctl_o[FLAG_LO +: NUM_OPS];
        msz   = ctl_o[MOD_LO+1 +: 3];
        c_rs1 = ctl_o[REG_W-1:0];
        c_rd  = ctl_o[3*REG_W-1:2*REG_W];
        if (!$isunknown({instr_i, cmp_i})) begin
            // R2
            one_sel_chk: assert (illegal_o || $onehot(sel))
                else $error("selector not one-hot for %h", instr_i);
            // R12
            illegal_quiet_chk: assert (!illegal_o || (ctl_o == '0 && imm_o == '0))
                else $error("illegal encoding left bits set for %h", instr_i);
            // R6
            mem_size_chk: assert ($onehot0(msz) &&
                                  (msz == 3'b000 || sel[OP_LOAD] || sel[OP_STORE]))
                else $error("access size bits wrong for %h", instr_i);
            // R8
            jal_link_chk: assert (illegal_o || instr_i[6:0] != OPC_JAL ||
                                  (imm_o[0] == 1'b0 && c_rs1 == {REG_W{1'b1}} &&
                                   sel[OP_JALR]))
                else $error("direct jump decode wrong for %h", instr_i);
            // R3
            write_rd_chk: assert (!ctl_o[MOD_LO] || sel[OP_ECALL] || c_rd != '0)
                else $error("register write with rd zero for %h", instr_i);
            // R13
            cmp_copy_chk: assert (illegal_o || ctl_o[MOD_LO+4] == cmp_i)
                else $error("compressed flag not copied for %h", instr_i);
        end
    end

endmodule

bind rv_op_decoder rv_op_decoder_chk #(.XLEN(XLEN), .REG_W(REG_W)) i_rv_op_decoder_chk (
    .instr_i   (instr_i),
    .cmp_i     (cmp_i),
    .ctl_o     (ctl_o),
    .imm_o     (imm_o),
    .illegal_o (illegal_o)
);

// File: tb/test_rv_op_decoder.sv
// Bench: sweeps every supported instruction over register and immediate
// patterns and compares against expectations built from the requirements.
module test_rv_op_decoder;

    localparam int CLK_P = 10;

    // Selector indices (R1 order)
    localparam int F_ADD = 0, F_SUB = 1, F_SLT = 2, F_AND = 3, F_OR = 4,
                   F_XOR = 5, F_SHF = 6, F_JALR = 7, F_BEQ = 8, F_BLT = 9,
                   F_LD = 10, F_ST = 11, F_MUL = 12, F_DIV = 13,
                   F_ECALL = 14, F_EBRK = 15;

    localparam logic [6:0] O_I = 7'b0010011, O_IW = 7'b0011011,
                           O_R = 7'b0110011, O_RW = 7'b0111011;
    localparam logic [6:0] M0 = 7'b0000000, M1 = 7'b0100000, MM = 7'b0000001;

    logic        clk = 1'b0;
    logic [31:0] instr_r = 32'h0;
    logic        cmp_r = 1'b0;
    logic [63:0] pc_r = 64'h0;
    logic [63:0] pc_w;
    logic [48:0] ctl_w;
    logic [63:0] imm_w;
    logic        ill_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rv_op_decoder i_rv_op_decoder (
        .instr_i   (instr_r),
        .cmp_i     (cmp_r),
        .pc_i      (pc_r),
        .pc_o      (pc_w),
        .ctl_o     (ctl_w),
        .imm_o     (imm_w),
        .illegal_o (ill_w)
    );

    // Current sweep pattern
    logic [4:0]  d5, a5, b5;
    logic [7:0]  d, a, b;
    logic        w;
    logic [11:0] iv;
    logic [12:0] bv;
    logic [19:0] uv;
    logic [20:0] jv;
    logic [5:0]  sh6;
    logic [4:0]  sh5;

    function automatic logic [48:0] mk(int op, bit wr, bit [2:0] msz, bit ct,
                                       bit sg, bit mp, bit md, bit wd,
                                       logic [7:0] r1, logic [7:0] r2,
                                       logic [7:0] rd);
        logic [48:0] v = '0;
        v[7:0] = r1; v[15:8] = r2; v[23:16] = rd;
        v[24] = wr; v[25] = msz[0]; v[26] = msz[1]; v[27] = msz[2];
        v[28] = ct; v[29] = sg; v[30] = mp; v[31] = md; v[32] = wd;
        v[33+op] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [2:0] f3, logic [6:0] op);
        return {f7, b5, a5, f3, d5, op};
    endfunction
    function automatic logic [31:0] enc_i(logic [11:0] im, logic [2:0] f3, logic [6:0] op);
        return {im, a5, f3, d5, op};
    endfunction
    function automatic logic [31:0] enc_s(logic [11:0] im, logic [2:0] f3);
        return {im[11:5], b5, a5, f3, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(logic [12:0] im, logic [2:0] f3);
        return {im[12], im[10:5], b5, a5, f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [63:0] sx12(logic [11:0] v); return {{52{v[11]}}, v}; endfunction
    function automatic logic [63:0] sx13(logic [12:0] v); return {{51{v[12]}}, v}; endfunction
    function automatic logic [63:0] sx21(logic [20:0] v); return {{43{v[20]}}, v}; endfunction

    task automatic chk(string tg, string nm, logic [31:0] ins, logic [48:0] ew,
                       logic [63:0] ei, logic c = 1'b0, logic eb = 1'b0);
        @(posedge clk);
        instr_r = ins;
        cmp_r   = c;
        pc_r    = {ins, ~ins};
        @(negedge clk);
        checks++;
        if (ctl_w !== ew) begin
            fails++;
            $display("FAIL %s %s ctl: actual=%h expected=%h", tg, nm, ctl_w, ew);
        end
        checks++;
        if (imm_w !== ei) begin
            fails++;
            $display("FAIL %s %s imm: actual=%h expected=%h", tg, nm, imm_w, ei);
        end
        checks++;
        if (ill_w !== eb) begin
            fails++;
            $display("FAIL R12 %s illegal: actual=%b expected=%b", nm, ill_w, eb);
        end
        checks++;
        if (pc_w !== {ins, ~ins}) begin
            fails++;
            $display("FAIL R13 %s pc: actual=%h expected=%h", nm, pc_w, {ins, ~ins});
        end
    endtask

    logic [4:0]  RDV [4] = '{5'd0, 5'd1, 5'd15, 5'd31};
    logic [4:0]  R1V [4] = '{5'd31, 5'd0, 5'd17, 5'd3};
    logic [4:0]  R2V [4] = '{5'd9, 5'd31, 5'd0, 5'd30};
    logic [11:0] IV  [4] = '{12'h000, 12'h001, 12'hFFF, 12'h800};
    logic [12:0] BV  [4] = '{13'h0000, 13'h0002, 13'h1FFE, 13'h1000};
    logic [19:0] UV  [4] = '{20'h00000, 20'h00001, 20'hFFFFF, 20'h80000};
    logic [20:0] JV  [4] = '{21'h000000, 21'h000002, 21'h1FFFFE, 21'h100000};
    logic [5:0]  SH6 [4] = '{6'd0, 6'd1, 6'd32, 6'd63};
    logic [4:0]  SH5 [4] = '{5'd0, 5'd1, 5'd17, 5'd31};

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        // Power-up: all-zero word is not an instruction (R12)
        @(negedge clk);
        checks++;
        if (ill_w !== 1'b1 || ctl_w !== '0) begin
            fails++;
            $display("FAIL R12 start: actual=%b/%h expected=1/0", ill_w, ctl_w);
        end

        for (int p = 0; p < 4; p++) begin
            d5 = RDV[p]; a5 = R1V[p]; b5 = R2V[p];
            d = 8'(d5); a = 8'(a5); b = 8'(b5);
            w = (d5 != 5'd0);
            iv = IV[p]; bv = BV[p]; uv = UV[p]; jv = JV[p];
            sh6 = SH6[p]; sh5 = SH5[p];

            // Register-immediate ALU (R3, R4, R5, R10, R11)
            chk("R11", "ADDI",  enc_i(iv, 3'b000, O_I), mk(F_ADD, w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R4",  "SLTI",  enc_i(iv, 3'b010, O_I), mk(F_SLT, w, 0, 0, 1, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R11", "SLTIU", enc_i(iv, 3'b011, O_I), mk(F_SLT, w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R10", "XORI",  enc_i(iv, 3'b100, O_I), mk(F_XOR, w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R3",  "ORI",   enc_i(iv, 3'b110, O_I), mk(F_OR,  w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R3",  "ANDI",  enc_i(iv, 3'b111, O_I), mk(F_AND, w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R11", "SLLI",  enc_i({6'b000000, sh6}, 3'b001, O_I), mk(F_SHF, w, 0, 0, 0, 0, 0, 0, a, 0, d), 64'(sh6));
            chk("R5",  "SRLI",  enc_i({6'b000000, sh6}, 3'b101, O_I), mk(F_SHF, w, 0, 0, 0, 1, 0, 0, a, 0, d), 64'(sh6));
            chk("R4",  "SRAI",  enc_i({6'b010000, sh6}, 3'b101, O_I), mk(F_SHF, w, 0, 0, 1, 1, 0, 0, a, 0, d), 64'(sh6));
            chk("R4",  "ADDIW", enc_i(iv, 3'b000, O_IW), mk(F_ADD, w, 0, 0, 0, 0, 0, 1, a, 0, d), sx12(iv));
            chk("R11", "SLLIW", enc_i({7'b0000000, sh5}, 3'b001, O_IW), mk(F_SHF, w, 0, 0, 0, 0, 0, 1, a, 0, d), 64'(sh5));
            chk("R5",  "SRLIW", enc_i({7'b0000000, sh5}, 3'b101, O_IW), mk(F_SHF, w, 0, 0, 0, 1, 0, 1, a, 0, d), 64'(sh5));
            chk("R4",  "SRAIW", enc_i({7'b0100000, sh5}, 3'b101, O_IW), mk(F_SHF, w, 0, 0, 1, 1, 0, 1, a, 0, d), 64'(sh5));

            // Register-register ALU (R2, R3, R4, R10)
            chk("R2",  "ADD",  enc_r(M0, 3'b000, O_R), mk(F_ADD, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R2",  "SUB",  enc_r(M1, 3'b000, O_R), mk(F_SUB, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R4",  "SLT",  enc_r(M0, 3'b010, O_R), mk(F_SLT, w, 0, 0, 1, 0, 0, 0, a, b, d), 64'd0);
            chk("R4",  "SLTU", enc_r(M0, 3'b011, O_R), mk(F_SLT, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R2",  "AND",  enc_r(M0, 3'b111, O_R), mk(F_AND, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R2",  "OR",   enc_r(M0, 3'b110, O_R), mk(F_OR,  w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R2",  "XOR",  enc_r(M0, 3'b100, O_R), mk(F_XOR, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R5",  "SLL",  enc_r(M0, 3'b001, O_R), mk(F_SHF, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R5",  "SRL",  enc_r(M0, 3'b101, O_R), mk(F_SHF, w, 0, 0, 0, 1, 0, 0, a, b, d), 64'd0);
            chk("R5",  "SRA",  enc_r(M1, 3'b101, O_R), mk(F_SHF, w, 0, 0, 1, 1, 0, 0, a, b, d), 64'd0);
            chk("R4",  "ADDW", enc_r(M0, 3'b000, O_RW), mk(F_ADD, w, 0, 0, 0, 0, 0, 1, a, b, d), 64'd0);
            chk("R4",  "SUBW", enc_r(M1, 3'b000, O_RW), mk(F_SUB, w, 0, 0, 0, 0, 0, 1, a, b, d), 64'd0);
            chk("R4",  "SLLW", enc_r(M0, 3'b001, O_RW), mk(F_SHF, w, 0, 0, 0, 0, 0, 1, a, b, d), 64'd0);
            chk("R5",  "SRLW", enc_r(M0, 3'b101, O_RW), mk(F_SHF, w, 0, 0, 0, 1, 0, 1, a, b, d), 64'd0);
            chk("R5",  "SRAW", enc_r(M1, 3'b101, O_RW), mk(F_SHF, w, 0, 0, 1, 1, 0, 1, a, b, d), 64'd0);

            // Multiply and divide (R4, R5)
            chk("R5",  "MUL",    enc_r(MM, 3'b000, O_R), mk(F_MUL, w, 0, 0, 1, 1, 0, 0, a, b, d), 64'd0);
            chk("R5",  "MULH",   enc_r(MM, 3'b001, O_R), mk(F_MUL, w, 0, 0, 1, 1, 1, 0, a, b, d), 64'd0);
            chk("R5",  "MULHSU", enc_r(MM, 3'b010, O_R), mk(F_MUL, w, 0, 0, 1, 0, 1, 0, a, b, d), 64'd0);
            chk("R5",  "MULHU",  enc_r(MM, 3'b011, O_R), mk(F_MUL, w, 0, 0, 0, 0, 1, 0, a, b, d), 64'd0);
            chk("R4",  "DIV",    enc_r(MM, 3'b100, O_R), mk(F_DIV, w, 0, 0, 1, 0, 0, 0, a, b, d), 64'd0);
            chk("R4",  "DIVU",   enc_r(MM, 3'b101, O_R), mk(F_DIV, w, 0, 0, 0, 0, 0, 0, a, b, d), 64'd0);
            chk("R5",  "REM",    enc_r(MM, 3'b110, O_R), mk(F_DIV, w, 0, 0, 1, 0, 1, 0, a, b, d), 64'd0);
            chk("R5",  "REMU",   enc_r(MM, 3'b111, O_R), mk(F_DIV, w, 0, 0, 0, 0, 1, 0, a, b, d), 64'd0);
            chk("R5",  "MULW",   enc_r(MM, 3'b000, O_RW), mk(F_MUL, w, 0, 0, 1, 1, 0, 1, a, b, d), 64'd0);
            chk("R4",  "DIVW",   enc_r(MM, 3'b100, O_RW), mk(F_DIV, w, 0, 0, 1, 0, 0, 1, a, b, d), 64'd0);
            chk("R4",  "DIVUW",  enc_r(MM, 3'b101, O_RW), mk(F_DIV, w, 0, 0, 0, 0, 0, 1, a, b, d), 64'd0);
            chk("R5",  "REMW",   enc_r(MM, 3'b110, O_RW), mk(F_DIV, w, 0, 0, 1, 0, 1, 1, a, b, d), 64'd0);
            chk("R5",  "REMUW",  enc_r(MM, 3'b111, O_RW), mk(F_DIV, w, 0, 0, 0, 0, 1, 1, a, b, d), 64'd0);

            // Upper immediates and jumps (R7, R8)
            chk("R7", "LUI",   {uv, d5, 7'b0110111}, mk(F_ADD, w, 0, 0, 0, 0, 0, 0, 8'd0, 0, d), {{32{uv[19]}}, uv, 12'h000});
            chk("R7", "AUIPC", {uv, d5, 7'b0010111}, mk(F_ADD, w, 0, 0, 0, 0, 0, 0, 8'd255, 0, d), {{32{uv[19]}}, uv, 12'h000});
            chk("R8", "JAL",   {jv[20], jv[10:1], jv[11], jv[19:12], d5, 7'b1101111},
                mk(F_JALR, w, 0, 0, 0, 0, 0, 0, 8'd255, 0, d), sx21(jv));
            chk("R8", "JALR",  enc_i(iv, 3'b000, 7'b1100111), mk(F_JALR, w, 0, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));

            // Branches (R3, R5, R10, R11)
            chk("R5",  "BEQ",  enc_b(bv, 3'b000), mk(F_BEQ, 0, 0, 0, 0, 0, 0, 0, a, b, 0), sx13(bv));
            chk("R5",  "BNE",  enc_b(bv, 3'b001), mk(F_BEQ, 0, 0, 0, 0, 1, 0, 0, a, b, 0), sx13(bv));
            chk("R4",  "BLT",  enc_b(bv, 3'b100), mk(F_BLT, 0, 0, 0, 1, 0, 0, 0, a, b, 0), sx13(bv));
            chk("R5",  "BGE",  enc_b(bv, 3'b101), mk(F_BLT, 0, 0, 0, 1, 1, 0, 0, a, b, 0), sx13(bv));
            chk("R10", "BLTU", enc_b(bv, 3'b110), mk(F_BLT, 0, 0, 0, 0, 0, 0, 0, a, b, 0), sx13(bv));
            chk("R11", "BGEU", enc_b(bv, 3'b111), mk(F_BLT, 0, 0, 0, 0, 1, 0, 0, a, b, 0), sx13(bv));

            // Loads and stores (R3, R6)
            chk("R6", "LB",  enc_i(iv, 3'b000, 7'b0000011), mk(F_LD, 0, 3'b000, 0, 1, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "LH",  enc_i(iv, 3'b001, 7'b0000011), mk(F_LD, 0, 3'b001, 0, 1, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "LW",  enc_i(iv, 3'b010, 7'b0000011), mk(F_LD, 0, 3'b010, 0, 1, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R4", "LD",  enc_i(iv, 3'b011, 7'b0000011), mk(F_LD, 0, 3'b100, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "LBU", enc_i(iv, 3'b100, 7'b0000011), mk(F_LD, 0, 3'b000, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "LHU", enc_i(iv, 3'b101, 7'b0000011), mk(F_LD, 0, 3'b001, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "LWU", enc_i(iv, 3'b110, 7'b0000011), mk(F_LD, 0, 3'b010, 0, 0, 0, 0, 0, a, 0, d), sx12(iv));
            chk("R6", "SB",  enc_s(iv, 3'b000), mk(F_ST, 0, 3'b000, 0, 0, 0, 0, 0, a, b, 0), sx12(iv));
            chk("R6", "SH",  enc_s(iv, 3'b001), mk(F_ST, 0, 3'b001, 0, 0, 0, 0, 0, a, b, 0), sx12(iv));
            chk("R6", "SW",  enc_s(iv, 3'b010), mk(F_ST, 0, 3'b010, 0, 0, 0, 0, 0, a, b, 0), sx12(iv));
            chk("R6", "SD",  enc_s(iv, 3'b011), mk(F_ST, 0, 3'b100, 0, 0, 0, 0, 0, a, b, 0), sx12(iv));

            // Compressed-form flag copied (R13)
            chk("R13", "ADDI.c", enc_i(iv, 3'b000, O_I), mk(F_ADD, w, 0, 1, 0, 0, 0, 0, a, 0, d), sx12(iv), 1'b1);
        end

        // System words and fence (R9)
        chk("R9", "ECALL",  32'h0000_0073, mk(F_ECALL, 1, 0, 0, 0, 0, 0, 0, 8'd17, 8'd11, 8'd10), 64'd0);
        chk("R9", "EBREAK", 32'h0010_0073, mk(F_EBRK, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 64'd0);
        chk("R9", "FENCE",  32'h0FF0_000F, mk(F_ADD, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 64'd0);
        chk("R9", "FENCEx", 32'h8FF5_818F, mk(F_ADD, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 64'd0);
        chk("R1", "ECALL.c", 32'h0000_0073, mk(F_ECALL, 1, 0, 1, 0, 0, 0, 0, 8'd17, 8'd11, 8'd10), 64'd0, 1'b1);

        // Unrecognised encodings (R12)
        chk("R12", "low00",   32'h0000_0010, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "opc0",    32'hFFFF_FF83 & 32'hFFFF_FF80 | 32'h0000_0007, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "f7bad",   32'h0420_81B3, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "slliTop", 32'h4010_9093, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "srliTop", 32'h2010_D093, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "csr",     32'h3000_2073, '0, 64'd0, 1'b1, 1'b1);
        chk("R12", "ld111",   32'h0000_7083, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "st100",   32'h0000_4023, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "br010",   32'h0000_2063, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "fencei",  32'h0000_100F, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "jalr001", 32'h0000_90E7, '0, 64'd0, 1'b0, 1'b1);
        chk("R12", "opw010",  32'h0000_A0BB, '0, 64'd0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule